// File: doc/BRIEF.md
# Idle-Slot Code Memory CRC Scanner

This block sits on the instruction-fetch path between a processor core and a synchronous code ROM. It checks the integrity of the stored program in the background. In every clock cycle where the core does not request a fetch, the block takes over the ROM address lines for that one cycle and reads the next byte of its sweep. In every other cycle the core's address passes straight through, so the core never waits.

The bytes come back in address order and are folded into a CRC-16 register, one whole byte per clock. Once the last byte of the address space has been absorbed, the block compares the result with a fingerprint supplied on an input and raises a sticky pass or fail flag. A single start pulse runs one sweep. With continuous mode held high, a new sweep begins automatically after each one ends, so the memory is re-checked without end.

Top module: `idle_crc_scanner`

## Requirements
- R1: When `cpu_fetch_req` is high, or no sweep is reading, `rom_addr` equals `cpu_addr` in the same cycle.
- R2: During a sweep the block drives its own address only in cycles where `cpu_fetch_req` is low. It drives every address from 0 up to 2^ADDR_W-1 exactly once, in ascending order, and then stops taking cycles.
- R3: The checksum is CRC-16 with polynomial 0x1021, processed MSB first, starting value 0xFFFF, no reflection and no final XOR. It covers the bytes in address order. The byte on `rom_rdata` is taken one cycle after the block's own read and at no other time.
- R4: A sweep ends with `pass`=1 and `fail`=0 if the CRC equals `expect_crc`, and with `pass`=0 and `fail`=1 otherwise. The flag holds until it is cleared or replaced.
- R5: `done` is a one-cycle pulse, two cycles after the cycle in which the last address was driven. `pass`/`fail` are valid in that same cycle, and `busy` is low in it.
- R6: A `start` pulse is accepted only when `busy` is low. It clears `pass` and `fail` from the next cycle and begins a sweep at address 0. A `start` pulse while `busy` is high has no effect on the sweep.
- R7: With `cont_mode` high at the `done` cycle, a new sweep begins in the next cycle without a start pulse. The previous verdict is kept until the new sweep replaces it. With `cont_mode` low, the block goes idle.
- R8: CPU fetch cycles pause the sweep. The scan address and the CRC are held, and the sweep resumes where it stopped, so the result does not depend on the pattern of fetches.
- R9: After reset, `busy`, `done`, `pass` and `fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a sweep when idle |
| cont_mode | input | 1 | Restart the sweep automatically after each completion |
| expect_crc | input | 16 | Fingerprint the final CRC is compared with |
| cpu_fetch_req | input | 1 | The core uses the fetch bus this cycle |
| cpu_addr | input | ADDR_W | Core fetch address |
| rom_addr | output | ADDR_W | Address presented to the code ROM |
| rom_rdata | input | 8 | ROM read data, one cycle after its address |
| busy | output | 1 | A sweep is reading or finishing |
| done | output | 1 | One-cycle sweep-complete pulse |
| pass | output | 1 | Sticky: last sweep matched the fingerprint |
| fail | output | 1 | Sticky: last sweep mismatched the fingerprint |

## Verification
The hardest case to reach is a sweep broken into many small pieces by fetch traffic: the read for a byte must be issued in one idle slot and its data absorbed in the next cycle, even when the core resumes fetching in that very cycle. The bench shrinks the address space to 64 bytes. It replays full sweeps under several fetch patterns: no traffic, two busy cycles out of three, pseudo-random traffic, and long busy bursts. For each it checks every stolen address against a running counter and computes the expected CRC arithmetically from the ROM model. It also drives a start pulse in the middle of a sweep, and runs a continuous-mode pair of sweeps in which the fingerprint changes between them.

// File: rtl/ics_pkg.sv
package ics_pkg;

    localparam int            CRC_W    = 16;
    localparam int            BYTE_W   = 8;
    localparam logic [15:0]   CRC_POLY = 16'h1021;
    localparam logic [15:0]   CRC_SEED = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_REPORT = 2'd3
    } sweep_st_e;

endpackage

// File: rtl/ics_crc_engine.sv
module ics_crc_engine #(
    parameter int               CRC_W  = 16,
    parameter int               DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY   = 16'h1021,
    parameter logic [CRC_W-1:0] SEED   = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              absorb,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc_nxt
);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } eng_s;

    eng_s eng_d, eng_q;

    // One whole byte per clock: the shift loop unrolls into XOR logic.
    function automatic logic [CRC_W-1:0] fold_byte(input logic [CRC_W-1:0] c,
                                                   input logic [DATA_W-1:0] b);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (r[CRC_W-1] ^ b[i])
                r = (r << 1) ^ POLY;
            else
                r = r << 1;
        end
        return r;
    endfunction

    always_comb begin
        eng_d = eng_q;
        if (init)
            eng_d.crc = SEED;
        else if (absorb)
            eng_d.crc = fold_byte(eng_q.crc, data);
        crc_nxt = eng_d.crc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            eng_q <= '{crc: SEED};
        else
            eng_q <= eng_d;
    end

    // R8: the CRC stays put whenever no byte arrives.
    a_r8_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !absorb) |=> $stable(eng_q.crc));

    // R3: every sweep starts from the seed.
    a_r3_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (eng_q.crc == SEED));

endmodule

// File: rtl/ics_sweep_seq.sv
module ics_sweep_seq
    import ics_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cont_mode,
    input  logic              cpu_fetch_req,
    output logic              steal,
    output logic [ADDR_W-1:0] scan_addr,
    output logic              absorb,
    output logic              crc_init,
    output logic              final_cmp,
    output logic              clr_verdict,
    output logic              busy,
    output logic              done
);

    localparam logic [ADDR_W-1:0] ADDR_LAST = {ADDR_W{1'b1}};

    typedef struct packed {
        sweep_st_e         state;
        logic [ADDR_W-1:0] addr;
        logic              tag;
    } seq_s;

    seq_s seq_d, seq_q;
    logic start_ok;
    logic auto_go;
    logic begin_sweep;

    always_comb begin
        start_ok    = start && (seq_q.state == ST_IDLE || seq_q.state == ST_REPORT);
        auto_go     = (seq_q.state == ST_REPORT) && cont_mode;
        begin_sweep = start_ok || auto_go;
        steal       = (seq_q.state == ST_SCAN) && !cpu_fetch_req;

        seq_d     = seq_q;
        seq_d.tag = steal;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (begin_sweep) begin
                    seq_d.state = ST_SCAN;
                    seq_d.addr  = '0;
                end
            end
            ST_SCAN: begin
                if (steal) begin
                    seq_d.addr = seq_q.addr + 1'b1;
                    if (seq_q.addr == ADDR_LAST)
                        seq_d.state = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                seq_d.state = ST_REPORT;
            end
            ST_REPORT: begin
                if (begin_sweep) begin
                    seq_d.state = ST_SCAN;
                    seq_d.addr  = '0;
                end else begin
                    seq_d.state = ST_IDLE;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase

        scan_addr   = seq_q.addr;
        absorb      = seq_q.tag;
        crc_init    = begin_sweep;
        final_cmp   = (seq_q.state == ST_DRAIN);
        clr_verdict = start_ok;
        busy        = (seq_q.state == ST_SCAN) || (seq_q.state == ST_DRAIN);
        done        = (seq_q.state == ST_REPORT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seq_q <= '{state: ST_IDLE, addr: '0, tag: 1'b0};
        else
            seq_q <= seq_d;
    end

    // R2: never takes a cycle the core is using.
    a_r2_no_steal_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_fetch_req |-> !steal);

    // R3: data is absorbed only right after the block's own read.
    a_r3_own_data_only: assert property (@(posedge clk) disable iff (!rst_n)
        absorb |-> $past(steal));

    // R8: the scan position is frozen while the core fetches.
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_SCAN && cpu_fetch_req) |=> $stable(seq_q.addr));

    // R5: completion is a single-cycle pulse.
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: the compare cycle is always followed by the report cycle.
    a_r5_drain_to_report: assert property (@(posedge clk) disable iff (!rst_n)
        final_cmp |=> done);

endmodule

// File: rtl/ics_verdict.sv
module ics_verdict (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  logic match,
    output logic pass,
    output logic fail
);

    typedef struct packed {
        logic pass;
        logic fail;
    } vrd_s;

    vrd_s vrd_d, vrd_q;

    always_comb begin
        vrd_d = vrd_q;
        if (clr) begin
            vrd_d.pass = 1'b0;
            vrd_d.fail = 1'b0;
        end else if (load) begin
            vrd_d.pass = match;
            vrd_d.fail = !match;
        end
        pass = vrd_q.pass;
        fail = vrd_q.fail;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            vrd_q <= '{pass: 1'b0, fail: 1'b0};
        else
            vrd_q <= vrd_d;
    end

    // R4: the two flags never both stand.
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));

    // R6: an accepted start wipes the verdict.
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!pass && !fail));

    // R4: without clear or load the verdict is sticky.
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load) |=> ($stable(pass) && $stable(fail)));

endmodule

// File: rtl/idle_crc_scanner.sv
module idle_crc_scanner
    import ics_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cont_mode,
    input  logic [CRC_W-1:0]  expect_crc,
    input  logic              cpu_fetch_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [BYTE_W-1:0] rom_rdata,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail
);

    logic              steal;
    logic [ADDR_W-1:0] scan_addr;
    logic              absorb;
    logic              crc_init;
    logic              final_cmp;
    logic              clr_verdict;
    logic [CRC_W-1:0]  crc_nxt;
    logic              crc_match;

    ics_sweep_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .cont_mode     (cont_mode),
        .cpu_fetch_req (cpu_fetch_req),
        .steal         (steal),
        .scan_addr     (scan_addr),
        .absorb        (absorb),
        .crc_init      (crc_init),
        .final_cmp     (final_cmp),
        .clr_verdict   (clr_verdict),
        .busy          (busy),
        .done          (done)
    );

    ics_crc_engine #(
        .CRC_W  (CRC_W),
        .DATA_W (BYTE_W),
        .POLY   (CRC_POLY),
        .SEED   (CRC_SEED)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (crc_init),
        .absorb  (absorb),
        .data    (rom_rdata),
        .crc_nxt (crc_nxt)
    );

    always_comb begin
        rom_addr  = steal ? scan_addr : cpu_addr;
        crc_match = (crc_nxt == expect_crc);
    end

    ics_verdict u_verdict (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_verdict),
        .load  (final_cmp),
        .match (crc_match),
        .pass  (pass),
        .fail  (fail)
    );

    // R1: core fetches always reach the ROM untouched.
    a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_fetch_req |-> (rom_addr == cpu_addr));

    // R5: done and busy never overlap.
    a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/idle_crc_scanner_bench.sv
`timescale 1ns/1ps
module idle_crc_scanner_bench;

    localparam int AW = 6;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          cont_mode;
    logic [15:0]   expect_crc;
    logic          cpu_fetch_req;
    logic [AW-1:0] cpu_addr;
    logic [AW-1:0] rom_addr;
    logic [7:0]    rom_rdata;
    logic          busy, done, pass, fail;

    always #5 clk = ~clk;

    idle_crc_scanner #(.ADDR_W(AW)) u_idle_crc_scanner (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .cont_mode     (cont_mode),
        .expect_crc    (expect_crc),
        .cpu_fetch_req (cpu_fetch_req),
        .cpu_addr      (cpu_addr),
        .rom_addr      (rom_addr),
        .rom_rdata     (rom_rdata),
        .busy          (busy),
        .done          (done),
        .pass          (pass),
        .fail          (fail)
    );

    logic [7:0] mem [N];
    always @(posedge clk) rom_rdata <= mem[rom_addr];

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int issued = 0;
    int last_cyc = -100;
    int pat = 4;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected CRC, computed with the byte-into-top-bits form.
    function automatic logic [15:0] ref_crc_bytes(input logic [7:0] b [], input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int k = 0; k < n; k++) begin
            c = c ^ {b[k], 8'h00};
            for (int j = 0; j < 8; j++)
                c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    function automatic logic [15:0] ref_crc_mem();
        logic [7:0] b [];
        b = new[N];
        for (int k = 0; k < N; k++) b[k] = mem[k];
        return ref_crc_bytes(b, N);
    endfunction

    task automatic fill(input int seed);
        for (int k = 0; k < N; k++)
            mem[k] = 8'((k * 37 + seed * 11) ^ (k >> 2) ^ (seed << 4));
    endtask

    // Core traffic generator.
    initial begin
        cpu_fetch_req = 1'b1;
        cpu_addr = '0;
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cpu_addr = lfsr[AW-1:0] ^ AW'(cyc);
            case (pat)
                0: cpu_fetch_req = 1'b0;
                1: cpu_fetch_req = (cyc % 3) != 0;
                2: cpu_fetch_req = lfsr[0] | lfsr[3];
                3: cpu_fetch_req = ((cyc / 20) % 2) == 0;
                default: cpu_fetch_req = 1'b1;
            endcase
        end
    end

    // Cycle monitor: address routing, sweep order and done timing.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (busy && !cpu_fetch_req && issued < N) begin
                chk(rom_addr == AW'(issued), "R2 scan address", int'(rom_addr), issued);
                issued++;
                if (issued == N) last_cyc = cyc;
            end else begin
                chk(rom_addr == cpu_addr, "R1 passthrough", int'(rom_addr), int'(cpu_addr));
            end
            if (done)
                chk(cyc == last_cyc + 2, "R5 done timing", cyc - last_cyc, 2);
            if ((start && !busy) || (done && cont_mode))
                issued = 0;
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (n < 5000) begin
            @(negedge clk);
            if (done) break;
            n++;
        end
        if (n >= 5000) chk(1'b0, "watchdog done", 0, 1);
    endtask

    task automatic run_sweep(input int p, input int seed, input bit corrupt);
        logic [15:0] e;
        fill(seed);
        e = ref_crc_mem();
        expect_crc = corrupt ? (e ^ 16'h0100) : e;
        pat = p;
        pulse_start();
        @(negedge clk);
        chk(!pass && !fail && busy, "R6 start clears verdict", {pass, fail, busy}, 3'b001);
        wait_done();
        chk(pass == !corrupt, "R4 pass flag", pass, !corrupt);
        chk(fail == corrupt, "R4 fail flag", fail, corrupt);
        chk(issued == N, "R2 full sweep", issued, N);
        chk(!busy, "R5 busy low at done", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] ref_msg [];
        rst_n = 1'b0;
        start = 1'b0;
        cont_mode = 1'b0;
        expect_crc = '0;
        fill(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !pass && !fail, "R9 reset state", {busy, done, pass, fail}, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R3: the reference model against the standard check string.
        ref_msg = new[9];
        for (int k = 0; k < 9; k++) ref_msg[k] = 8'h31 + 8'(k);
        chk(ref_crc_bytes(ref_msg, 9) == 16'h29B1, "R3 reference check value",
            int'(ref_crc_bytes(ref_msg, 9)), 16'h29B1);

        // R3, R8: CRC correct under several fetch patterns.
        run_sweep(0, 1, 1'b0);
        run_sweep(1, 2, 1'b0);
        run_sweep(2, 3, 1'b0);
        run_sweep(3, 4, 1'b0);
        run_sweep(2, 5, 1'b1);

        // R4: verdict sticky after an idle spell.
        run_sweep(1, 6, 1'b0);
        pat = 2;
        repeat (15) @(negedge clk);
        chk(pass && !fail && !busy, "R4 sticky", {pass, fail}, 2'b10);

        // R6: a start while busy has no effect.
        fill(7);
        expect_crc = ref_crc_mem();
        pat = 1;
        pulse_start();
        repeat (30) @(negedge clk);
        pulse_start();
        @(negedge clk);
        chk(busy, "R6 busy kept", busy, 1);
        wait_done();
        chk(pass && !fail, "R6 sweep unaffected", {pass, fail}, 2'b10);
        chk(issued == N, "R6 no restart", issued, N);

        // R7: continuous mode, fingerprint changed between sweeps.
        fill(8);
        expect_crc = ref_crc_mem();
        cont_mode = 1'b1;
        pat = 3;
        pulse_start();
        wait_done();
        chk(pass && !fail, "R7 first sweep", {pass, fail}, 2'b10);
        expect_crc = expect_crc ^ 16'h8001;
        repeat (20) @(negedge clk);
        chk(busy && pass, "R7 auto restart keeps verdict", {busy, pass}, 2'b11);
        cont_mode = 1'b0;
        wait_done();
        chk(!pass && fail, "R7 second sweep", {pass, fail}, 2'b01);
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R7 stops without cont_mode", {busy, done}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule